// File: doc/BRIEF.md
# Deferred Exception Poison Tracker

This block sits beside a register file and tracks a poison flag per register, so that a fatal fault raised by a speculatively executed instruction is not signalled when it occurs. The fault is recorded as poison on the instruction's destination register instead. It is reported only if the program actually depends on that value. That happens either through a non-speculative read of the poisoned register, which raises a fatal trap, or through a check instruction left at the instruction's original program position, which requests recovery.

Each cycle the pipeline presents at most one instruction. The instruction carries its kind, a speculative flag, up to two source operands with use flags, an optional destination write with data, and an exception flag with a class (fatal or resumable). The block updates the register data and the poison flags in the same cycle. Its trap, recovery and service outputs are registered single-cycle pulses. Source data for the presented operands is read combinationally.

Top module: `poison_track`

## Requirements
- R1: After reset every poison flag is clear, every register reads zero, and trap_o, recover_o and service_o are low.
- R2: An operation (ins_kind_i = 0) with ins_we_i set, no exception and no poisoned used source writes ins_data_i to the destination and clears its poison flag. This holds whether or not the operation is speculative.
- R3: A speculative operation (ins_spec_i = 1) with a fatal exception (ins_exc_i = 1, ins_exc_fatal_i = 1) and ins_we_i set raises no pulse. It poisons its destination, and the destination then reads as zero.
- R4: A resumable exception (ins_exc_fatal_i = 0) on any operation, or any exception on a non-speculative operation, pulses service_o on the next cycle and leaves the destination unchanged. This applies unless R6 applies to the same operation.
- R5: A speculative operation that reads a poisoned used source raises no pulse and, when ins_we_i is set, poisons its destination, which then reads as zero.
- R6: A non-speculative operation that reads a poisoned used source pulses trap_o on the next cycle, with trap_idx_o giving the poisoned source. Source A is reported when both sources are poisoned. The operation writes nothing.
- R7: A check instruction (ins_kind_i = 1) tests the poison flag of source A. It pulses recover_o on the next cycle, with recover_idx_o = source A, if and only if that flag is set. A check never writes a register and never traps.
- R8: A source whose use flag (ins_use_a_i or ins_use_b_i) is low is ignored for trapping and for poison propagation, even if it is poisoned.
- R9: Each pulse output is high for exactly the cycle after the instruction that caused it. All pulse outputs are low after a cycle with no valid instruction, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Instruction present this cycle |
| ins_kind_i | input | 1 | 0 = operation, 1 = poison check |
| ins_spec_i | input | 1 | Instruction was hoisted speculatively |
| ins_use_a_i | input | 1 | Source A is read |
| ins_src_a_i | input | IW | Source A index (also the checked register) |
| ins_use_b_i | input | 1 | Source B is read |
| ins_src_b_i | input | IW | Source B index |
| ins_we_i | input | 1 | Operation writes a destination |
| ins_dst_i | input | IW | Destination index |
| ins_data_i | input | DW | Result data |
| ins_exc_i | input | 1 | Operation raised an exception |
| ins_exc_fatal_i | input | 1 | 1 = fatal class, 0 = resumable |
| rd_a_o | output | DW | Current data of source A |
| rd_b_o | output | DW | Current data of source B |
| trap_o | output | 1 | Fatal trap pulse |
| trap_idx_o | output | IW | Register whose poison caused the trap |
| recover_o | output | 1 | Recovery request pulse |
| recover_idx_o | output | IW | Register found poisoned by the check |
| service_o | output | 1 | Service-now exception pulse |

## Verification
The assertions check several properties on every cycle. The pulse outputs are mutually exclusive and stay silent after idle cycles. Every trap and recovery pulse traces back to a matching instruction kind in the previous cycle. A clean write always leaves its destination unpoisoned, and a speculative fatal fault always leaves it poisoned. Other behaviour can only be shown by the bench's scenarios against a reference model. This covers the reported trap index and the source A priority, the zero read-back of poisoned registers, and the way poison propagates through chains of speculative operations. It also covers the ignoring of unused operands and the fact that a trapping or serviced operation leaves its destination untouched.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic {
    KIND_OP  = 1'b0,
    KIND_CHK = 1'b1
  } kind_e;

  typedef struct packed {
    logic trap;
    logic rec;
    logic svc;
  } pulse_t;
endpackage

// File: rtl/pt_state.sv
module pt_state #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            wr_nat_i,
  input  logic [IW-1:0]   rd_a_idx_i,
  input  logic [IW-1:0]   rd_b_idx_i,
  output logic [DW-1:0]   rd_a_o,
  output logic [DW-1:0]   rd_b_o,
  output logic [NREG-1:0] nat_o
);
  logic [DW-1:0] data_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        nat_o[g]  <= 1'b0;
      end else if (hit) begin
        data_q[g] <= wr_data_i;
        nat_o[g]  <= wr_nat_i;
      end
    end
  end

  assign rd_a_o = data_q[rd_a_idx_i];
  assign rd_b_o = data_q[rd_b_idx_i];
endmodule

// File: rtl/pt_decide.sv
module pt_decide #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            valid_i,
  input  pt_pkg::kind_e   kind_i,
  input  logic            spec_i,
  input  logic            use_a_i,
  input  logic [IW-1:0]   src_a_i,
  input  logic            use_b_i,
  input  logic [IW-1:0]   src_b_i,
  input  logic            we_i,
  input  logic [DW-1:0]   data_i,
  input  logic            exc_i,
  input  logic            fatal_i,
  input  logic [NREG-1:0] nat_i,
  output logic            wr_en_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            wr_nat_o,
  output pt_pkg::pulse_t  pulse_o,
  output logic [IW-1:0]   trap_idx_o
);
  logic pa, pb, src_bad;

  assign pa      = use_a_i && nat_i[src_a_i];
  assign pb      = use_b_i && nat_i[src_b_i];
  assign src_bad = pa || pb;

  always_comb begin
    wr_en_o    = 1'b0;
    wr_nat_o   = 1'b0;
    wr_data_o  = data_i;
    pulse_o    = '0;
    trap_idx_o = pa ? src_a_i : src_b_i;
    if (valid_i) begin
      if (kind_i == pt_pkg::KIND_CHK) begin
        pulse_o.rec = nat_i[src_a_i];
      end else if (!spec_i && src_bad) begin
        pulse_o.trap = 1'b1;
      end else if (exc_i && (!spec_i || !fatal_i)) begin
        pulse_o.svc = 1'b1;
      end else if (we_i) begin
        // speculative fault or poisoned input: defer by poisoning the result
        wr_en_o  = 1'b1;
        wr_nat_o = spec_i && (exc_i || src_bad);
        if (wr_nat_o) wr_data_o = '0;
      end
    end
  end
endmodule

// File: rtl/pt_pulse.sv
module pt_pulse #(
  parameter int IW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  pt_pkg::pulse_t pulse_i,
  input  logic [IW-1:0]  trap_idx_i,
  input  logic [IW-1:0]  rec_idx_i,
  output logic           trap_o,
  output logic [IW-1:0]  trap_idx_o,
  output logic           recover_o,
  output logic [IW-1:0]  recover_idx_o,
  output logic           service_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o        <= 1'b0;
      recover_o     <= 1'b0;
      service_o     <= 1'b0;
      trap_idx_o    <= '0;
      recover_idx_o <= '0;
    end else begin
      trap_o        <= pulse_i.trap;
      recover_o     <= pulse_i.rec;
      service_o     <= pulse_i.svc;
      trap_idx_o    <= pulse_i.trap ? trap_idx_i : '0;
      recover_idx_o <= pulse_i.rec ? rec_idx_i : '0;
    end
  end
endmodule

// File: rtl/poison_track.sv
module poison_track #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ins_valid_i,
  input  logic          ins_kind_i,
  input  logic          ins_spec_i,
  input  logic          ins_use_a_i,
  input  logic [IW-1:0] ins_src_a_i,
  input  logic          ins_use_b_i,
  input  logic [IW-1:0] ins_src_b_i,
  input  logic          ins_we_i,
  input  logic [IW-1:0] ins_dst_i,
  input  logic [DW-1:0] ins_data_i,
  input  logic          ins_exc_i,
  input  logic          ins_exc_fatal_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  output logic          trap_o,
  output logic [IW-1:0] trap_idx_o,
  output logic          recover_o,
  output logic [IW-1:0] recover_idx_o,
  output logic          service_o
);
  logic [NREG-1:0] nat_vec;
  logic            wr_en, wr_nat;
  logic [DW-1:0]   wr_data;
  logic [IW-1:0]   trap_idx;
  pt_pkg::pulse_t  pulse;

  pt_state #(.NREG(NREG), .DW(DW)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (ins_dst_i),
    .wr_data_i  (wr_data),
    .wr_nat_i   (wr_nat),
    .rd_a_idx_i (ins_src_a_i),
    .rd_b_idx_i (ins_src_b_i),
    .rd_a_o     (rd_a_o),
    .rd_b_o     (rd_b_o),
    .nat_o      (nat_vec)
  );

  pt_decide #(.NREG(NREG), .DW(DW)) u_decide (
    .valid_i    (ins_valid_i),
    .kind_i     (pt_pkg::kind_e'(ins_kind_i)),
    .spec_i     (ins_spec_i),
    .use_a_i    (ins_use_a_i),
    .src_a_i    (ins_src_a_i),
    .use_b_i    (ins_use_b_i),
    .src_b_i    (ins_src_b_i),
    .we_i       (ins_we_i),
    .data_i     (ins_data_i),
    .exc_i      (ins_exc_i),
    .fatal_i    (ins_exc_fatal_i),
    .nat_i      (nat_vec),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .wr_nat_o   (wr_nat),
    .pulse_o    (pulse),
    .trap_idx_o (trap_idx)
  );

  pt_pulse #(.IW(IW)) u_pulse (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pulse_i       (pulse),
    .trap_idx_i    (trap_idx),
    .rec_idx_i     (ins_src_a_i),
    .trap_o        (trap_o),
    .trap_idx_o    (trap_idx_o),
    .recover_o     (recover_o),
    .recover_idx_o (recover_idx_o),
    .service_o     (service_o)
  );
endmodule

// File: rtl/poison_track_chk.sv
module poison_track_chk #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ins_valid_i,
  input logic            ins_kind_i,
  input logic            ins_spec_i,
  input logic            ins_use_a_i,
  input logic [IW-1:0]   ins_src_a_i,
  input logic            ins_use_b_i,
  input logic [IW-1:0]   ins_src_b_i,
  input logic            ins_we_i,
  input logic [IW-1:0]   ins_dst_i,
  input logic            ins_exc_i,
  input logic            ins_exc_fatal_i,
  input logic            trap_o,
  input logic            recover_o,
  input logic            service_o,
  input logic [NREG-1:0] nat_vec
);
  logic clean_op, spec_fault;
  assign clean_op = ins_valid_i && !ins_kind_i && ins_we_i && !ins_exc_i &&
                    !(ins_use_a_i && nat_vec[ins_src_a_i]) &&
                    !(ins_use_b_i && nat_vec[ins_src_b_i]);
  assign spec_fault = ins_valid_i && !ins_kind_i && ins_spec_i && ins_we_i &&
                      ins_exc_i && ins_exc_fatal_i;

  // R2
  clean_write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_op |=> !nat_vec[$past(ins_dst_i)]);
  // R3
  spec_fault_poisons_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_fault |=> nat_vec[$past(ins_dst_i)] && !trap_o && !service_o);
  // R6
  trap_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(ins_valid_i && !ins_spec_i && !ins_kind_i));
  // R7
  recover_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> $past(ins_valid_i && ins_kind_i));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_i |=> !trap_o && !recover_o && !service_o);
  // R9
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_o, recover_o, service_o}));
endmodule

bind poison_track poison_track_chk #(.NREG(NREG)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ins_valid_i     (ins_valid_i),
  .ins_kind_i      (ins_kind_i),
  .ins_spec_i      (ins_spec_i),
  .ins_use_a_i     (ins_use_a_i),
  .ins_src_a_i     (ins_src_a_i),
  .ins_use_b_i     (ins_use_b_i),
  .ins_src_b_i     (ins_src_b_i),
  .ins_we_i        (ins_we_i),
  .ins_dst_i       (ins_dst_i),
  .ins_exc_i       (ins_exc_i),
  .ins_exc_fatal_i (ins_exc_fatal_i),
  .trap_o          (trap_o),
  .recover_o       (recover_o),
  .service_o       (service_o),
  .nat_vec         (nat_vec)
);

// File: tb/poison_track_bench.sv
module poison_track_bench;
  localparam int CLK_P = 10;
  localparam int NREG  = 4;
  localparam int DW    = 8;
  localparam int IW    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, kind = 0, spec = 0, ua = 0, ub = 0, we = 0, exc = 0, fat = 0;
  logic [IW-1:0] sa = 0, sb = 0, dst = 0;
  logic [DW-1:0] data = 0;
  logic [DW-1:0] rd_a, rd_b;
  logic trap, rec, svc;
  logic [IW-1:0] trap_idx, rec_idx;

  int total = 0, bad = 0;
  logic [DW-1:0] m_data [NREG];
  bit            m_nat  [NREG];

  always #(CLK_P/2) clk = ~clk;

  poison_track #(.NREG(NREG), .DW(DW)) u_poison_track (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(valid), .ins_kind_i(kind),
    .ins_spec_i(spec), .ins_use_a_i(ua), .ins_src_a_i(sa), .ins_use_b_i(ub),
    .ins_src_b_i(sb), .ins_we_i(we), .ins_dst_i(dst), .ins_data_i(data),
    .ins_exc_i(exc), .ins_exc_fatal_i(fat), .rd_a_o(rd_a), .rd_b_o(rd_b),
    .trap_o(trap), .trap_idx_o(trap_idx), .recover_o(rec),
    .recover_idx_o(rec_idx), .service_o(svc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(input bit k, input bit sp, input bit a_use, input int a,
                       input bit b_use, input int b, input bit w, input int d,
                       input int dat, input bit e, input bit f, input string tag);
    bit pa, pb, e_trap, e_rec, e_svc;
    int e_tidx, e_ridx;
    valid = 1; kind = k; spec = sp; ua = a_use; sa = IW'(a); ub = b_use;
    sb = IW'(b); we = w; dst = IW'(d); data = DW'(dat); exc = e; fat = f;
    pa = a_use && m_nat[a];
    pb = b_use && m_nat[b];
    e_trap = 0; e_rec = 0; e_svc = 0; e_tidx = 0; e_ridx = 0;
    if (k) begin
      e_rec = m_nat[a]; e_ridx = e_rec ? a : 0;
    end else if (!sp && (pa || pb)) begin
      e_trap = 1; e_tidx = pa ? a : b;
    end else if (e && (!sp || !f)) begin
      e_svc = 1;
    end else if (w) begin
      m_nat[d]  = sp && (e || pa || pb);
      m_data[d] = m_nat[d] ? '0 : DW'(dat);
    end
    @(posedge clk); @(negedge clk);
    chk(trap == e_trap, tag, "trap", int'(trap), int'(e_trap));
    chk(trap_idx == IW'(e_tidx), tag, "trap_idx", int'(trap_idx), e_tidx);
    chk(rec == e_rec, tag, "recover", int'(rec), int'(e_rec));
    chk(rec_idx == IW'(e_ridx), tag, "recover_idx", int'(rec_idx), e_ridx);
    chk(svc == e_svc, tag, "service", int'(svc), int'(e_svc));
    chk(rd_a == m_data[a], tag, "rd_a", int'(rd_a), int'(m_data[a]));
    chk(rd_b == m_data[b], tag, "rd_b", int'(rd_b), int'(m_data[b]));
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_nat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!trap && !rec && !svc, "R1", "pulses", int'({trap, rec, svc}), 0);
    for (int r = 0; r < NREG; r++) begin
      issue(1, 0, 0, r, 0, r, 0, 0, 0, 0, 0, "R1");
    end
    issue(0, 0, 0, 0, 0, 0, 1, 1, 8'h11, 0, 0, "R2");
    issue(0, 1, 0, 1, 0, 0, 1, 1, 8'h22, 1, 1, "R3");
    issue(1, 0, 0, 1, 0, 0, 1, 1, 8'h33, 0, 0, "R7");
    issue(0, 1, 1, 1, 0, 0, 1, 2, 8'h44, 0, 0, "R5");
    issue(1, 1, 0, 2, 0, 2, 0, 0, 0, 0, 0, "R5");
    issue(0, 0, 0, 2, 0, 1, 1, 3, 8'h55, 0, 0, "R8");
    issue(0, 0, 0, 3, 1, 2, 1, 3, 8'h66, 0, 0, "R6");
    issue(0, 0, 1, 1, 1, 2, 1, 0, 8'h77, 0, 0, "R6");
    issue(0, 1, 0, 0, 0, 0, 1, 0, 8'h88, 1, 0, "R4");
    issue(0, 0, 0, 0, 0, 0, 1, 0, 8'h99, 1, 1, "R4");
    issue(0, 1, 0, 0, 0, 1, 1, 1, 8'hAA, 0, 0, "R2");
    issue(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    valid = 0;
    @(posedge clk); @(negedge clk);
    // R9 idle cycle is silent
    chk(!trap && !rec && !svc, "R9", "idle", int'({trap, rec, svc}), 0);
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] h;
      h = 32'(n) * 32'd2654435761 + 32'd12345;
      issue(h[31:29] == 3'd0, h[5], h[8], int'(h[10:9]), h[11], int'(h[13:12]),
            h[6] | h[7], int'(h[15:14]), int'(h[23:16]), h[3:1] == 3'd0, h[4],
            "R9");
    end
    valid = 0;
    @(posedge clk); @(negedge clk);
    chk(!trap && !rec && !svc, "R9", "idle_end", int'({trap, rec, svc}), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule